// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This peripheral tallies processor activity on two independent counters. Every counter has its own 16-bit control word, which selects a 6-bit event code and holds enable, start and clear controls. The processor provides one single-cycle strobe per event code. One code counts every clock as elapsed time. A few codes are unassigned and never count.

Software reaches the unit over a simple synchronous bus. The bus has a byte address, 16-bit write data, a write strobe, a read strobe and 32-bit read data. A counter is wider than one bus word, so it is read as a high word and then a low word. Reading the high word saves the low half in a per-counter shadow, so the pair of reads returns one consistent value. The usual sequence is: write the clear bit, then write the event code with enable and start, and later write zero to stop. A stopped counter keeps its value.

Top module: `perf_counter_unit`

## Requirements
- R1: There are two counters. Each one counts only the events selected by its own control word, and the other counter's traffic does not affect it.
- R2: Control word layout, read at byte 0x00 for counter 0 and 0x04 for counter 1, in the low 16 bits of the read data. Bits 5:0 hold the event code, bit 8 a clock-source flag, bit 14 start and bit 15 enable. All other bits read as 0. The clock-source flag is stored and read back, and it has no effect on counting.
- R3: Bit 13 of a control write zeroes that counter at the write edge, and this takes priority over an increment on the same edge. Bit 13 always reads back as 0.
- R4: A counter adds one on a clock edge when the control word held before that edge has both enable and start set and the strobe for the selected code is high in the cycle before the edge. A control write changes counting from the following edge onward.
- R5: Code 0x23 counts every clock edge, whatever the strobes are.
- R6: Codes 0x00, 0x0c, 0x1b to 0x20, 0x26 and 0x2a to 0x3f never change a counter, even when their strobes are high.
- R7: Writing a control word with enable clear stops the counter and keeps its value. Enabling again without bit 13 continues from that value.
- R8: Counter n's high word is at byte 0x20+8n and returns the count bits above the low half, zero-extended. Its low word is at 0x24+8n and returns the low half. Read data appears the cycle after the read strobe and holds while no read is made.
- R9: A high-word read stores the counter's low half in a shadow. The next low-word read of that counter returns the shadow and uses it up. A low-word read with no shadow pending returns the live low half.
- R10: A counter at its maximum value wraps to 0 on the next counted event.
- R11: After reset, both control words, both counters and the read data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 16 | Write data for control words |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| evt_pulse | input | 64 | One single-cycle strobe per event code, bit index equals code |
| bus_rdata | output | 32 | Registered read data |

## Verification
The assertions assume that the bus carries at most one access per cycle: a control write and a read of the same counter never share a cycle. They also assume that address and data are valid whenever a strobe is high. The bench drives every input at the falling clock edge and makes one access per bus operation, so it stays within these assumptions. Strobes for unassigned or unselected codes are driven freely, including all-ones patterns, because the requirements say those strobes must have no effect. The small bench configuration narrows the counter so that wrap-around can be reached in about a thousand cycles.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int CODE_W    = 6;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam logic [CODE_W-1:0] ELAPSED_CODE = 6'h23;

    typedef struct packed {
        logic              en;
        logic              start;
        logic              clk_sel;
        logic [CODE_W-1:0] code;
    } ctrl_t;

    // True for codes that are allowed to advance a counter.
    function automatic logic code_counts(input logic [CODE_W-1:0] c);
        logic ok;
        ok = (c >= 6'h01) && (c <= 6'h29);
        if (c == 6'h0c || c == 6'h26) ok = 1'b0;
        if (c >= 6'h1b && c <= 6'h20) ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/perfmon_event_match.sv
module perfmon_event_match
    import perfmon_pkg::*;
(
    input  logic [CODE_W-1:0]    code,
    input  logic [NUM_CODES-1:0] evt_pulse,
    output logic                 hit
);
    always_comb begin
        hit = 1'b0;
        if (code_counts(code)) begin
            hit = (code == ELAPSED_CODE) ? 1'b1 : evt_pulse[code];
        end
    end
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter
    import perfmon_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int LOW_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_we,
    input  logic [15:0]          ctrl_wdata,
    input  logic                 hi_rd,
    input  logic                 lo_rd,
    input  logic [NUM_CODES-1:0] evt_pulse,
    output logic [15:0]          ctrl_rdata,
    output logic [31:0]          hi_rdata,
    output logic [31:0]          lo_rdata
);
    localparam int HIGH_W = CNT_W - LOW_W;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  cnt;
        logic [LOW_W-1:0]  shadow;
        logic              shadow_vld;
    } state_t;

    state_t st_d, st_q;
    logic   hit;
    logic   clr_req;
    logic   unused_wbits;

    assign unused_wbits = ^{ctrl_wdata[12:9], ctrl_wdata[7:6]};
    assign clr_req      = ctrl_we && ctrl_wdata[13];

    perfmon_event_match u_match (
        .code      (st_q.ctrl.code),
        .evt_pulse (evt_pulse),
        .hit       (hit)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.ctrl.code    = ctrl_wdata[CODE_W-1:0];
            st_d.ctrl.clk_sel = ctrl_wdata[8];
            st_d.ctrl.start   = ctrl_wdata[14];
            st_d.ctrl.en      = ctrl_wdata[15];
        end
        if (clr_req) begin
            st_d.cnt = '0;
        end else if (st_q.ctrl.en && st_q.ctrl.start && hit) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (hi_rd) begin
            st_d.shadow     = st_q.cnt[LOW_W-1:0];
            st_d.shadow_vld = 1'b1;
        end else if (lo_rd) begin
            st_d.shadow_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_rdata = {st_q.ctrl.en, st_q.ctrl.start, 1'b0, 4'b0000,
                         st_q.ctrl.clk_sel, 2'b00, st_q.ctrl.code};
    assign hi_rdata   = 32'(st_q.cnt[CNT_W-1:LOW_W]);
    assign lo_rdata   = st_q.shadow_vld ? 32'(st_q.shadow)
                                        : 32'(st_q.cnt[LOW_W-1:0]);

    // R3: clear zeroes the counter at the write edge
    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> st_q.cnt == '0);

    // R7: without enable and start the counter holds
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_we && !(st_q.ctrl.en && st_q.ctrl.start)) |=> $stable(st_q.cnt));

    // R6: unassigned codes never advance the counter
    assert_unassigned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_we && !code_counts(st_q.ctrl.code)) |=> $stable(st_q.cnt));

    // R5: elapsed-time code advances every edge
    assert_elapsed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_req && st_q.ctrl.en && st_q.ctrl.start && st_q.ctrl.code == ELAPSED_CODE)
        |=> st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1));

    // R4, R10: without clear the count moves by at most one, modulo its width
    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_req |=> (st_q.cnt == $past(st_q.cnt)) ||
                     (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));

    initial begin
        assert_width_R8: assert (HIGH_W >= 1 && HIGH_W <= 16 && LOW_W <= 32);
    end
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
    import perfmon_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_CNT   = 2,
    parameter int CNT_W     = 48,
    parameter int LOW_W     = 32,
    parameter int CTRL_BASE = 'h00,
    parameter int CNT_BASE  = 'h20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [15:0]          bus_wdata,
    input  logic                 bus_we,
    input  logic                 bus_re,
    input  logic [NUM_CODES-1:0] evt_pulse,
    output logic [31:0]          bus_rdata
);
    localparam int CTRL_STRIDE = 4;
    localparam int CNT_STRIDE  = 8;

    logic [NUM_CNT-1:0] ctrl_sel, hi_sel, lo_sel;
    logic [15:0]        ctrl_rd [NUM_CNT];
    logic [31:0]        hi_rd   [NUM_CNT];
    logic [31:0]        lo_rd   [NUM_CNT];
    logic [31:0]        rdata_d, rdata_q;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign ctrl_sel[i] = bus_addr == ADDR_W'(CTRL_BASE + CTRL_STRIDE * i);
        assign hi_sel[i]   = bus_addr == ADDR_W'(CNT_BASE + CNT_STRIDE * i);
        assign lo_sel[i]   = bus_addr == ADDR_W'(CNT_BASE + CNT_STRIDE * i + 4);

        perfmon_counter #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_counter (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_we    (bus_we && ctrl_sel[i]),
            .ctrl_wdata (bus_wdata),
            .hi_rd      (bus_re && hi_sel[i]),
            .lo_rd      (bus_re && lo_sel[i]),
            .evt_pulse  (evt_pulse),
            .ctrl_rdata (ctrl_rd[i]),
            .hi_rdata   (hi_rd[i]),
            .lo_rdata   (lo_rd[i])
        );

        // R3: the clear bit never reads back as set
        assert_clr_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_re && ctrl_sel[i]) |=> bus_rdata[13] == 1'b0);
    end

    always_comb begin
        rdata_d = rdata_q;
        if (bus_re) begin
            rdata_d = '0;
            for (int i = 0; i < NUM_CNT; i++) begin
                if (ctrl_sel[i]) rdata_d = {16'h0000, ctrl_rd[i]};
                if (hi_sel[i])   rdata_d = hi_rd[i];
                if (lo_sel[i])   rdata_d = lo_rd[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;

    // R8: read data only changes after a read strobe
    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/perf_counter_unit_tb_top.sv
module perf_counter_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam int LOW_W      = 6;
    localparam logic [15:0] EN  = 16'h8000;
    localparam logic [15:0] ST  = 16'h4000;
    localparam logic [15:0] CLR = 16'h2000;
    localparam logic [15:0] CKS = 16'h0100;
    localparam logic [7:0] A_CTRL0 = 8'h00, A_CTRL1 = 8'h04;
    localparam logic [7:0] A_HI0 = 8'h20, A_LO0 = 8'h24, A_HI1 = 8'h28, A_LO1 = 8'h2C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [63:0] evt_pulse = '0;
    logic [31:0] bus_rdata;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    perf_counter_unit #(.CNT_W(CNT_W), .LOW_W(LOW_W)) dut_i (
        .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_re, .evt_pulse, .bus_rdata
    );

    function automatic bit assigned(input int c);
        if (c < 1 || c > 41) return 1'b0;
        if (c == 12 || c == 38) return 1'b0;
        if (c >= 27 && c <= 32) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        v = bus_rdata;
    endtask

    task automatic idle(input int n, input logic [63:0] p);
        for (int k = 0; k < n; k++) begin
            evt_pulse = p;
            @(negedge clk);
        end
        evt_pulse = '0;
    endtask

    task automatic rd_cnt(input int n, output logic [63:0] v);
        logic [31:0] h, l;
        rd(n == 0 ? A_HI0 : A_HI1, h);
        rd(n == 0 ? A_LO0 : A_LO1, l);
        v = (64'(h) << LOW_W) | 64'(l);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state of every register
        rd(A_CTRL0, v); chk("R11 ctrl0", v, 0);
        rd(A_CTRL1, v); chk("R11 ctrl1", v, 0);
        rd(A_HI0, v);   chk("R11 hi0", v, 0);
        rd(A_LO0, v);   chk("R11 lo0", v, 0);
        rd(A_HI1, v);   chk("R11 hi1", v, 0);
        rd(A_LO1, v);   chk("R11 lo1", v, 0);

        // R2, R3: layout, reserved bits zero, clear bit reads 0
        wr(A_CTRL0, 16'hFFFF & (EN | ST | CLR | CKS | 16'h1EC0 | 16'h15));
        rd(A_CTRL0, v); chk("R2 R3 ctrl0 readback", v, 32'h0000_C115);
        wr(A_CTRL1, CKS | 16'h3F);
        rd(A_CTRL1, v); chk("R2 ctrl1 readback", v, 32'h0000_013F);
        wr(A_CTRL0, 16'h0000);
        wr(A_CTRL1, 16'h0000);

        // R4 R5 R6: sweep every code, all strobes high, then all but the selected one
        for (int code = 0; code < 64; code++) begin
            for (int ph = 0; ph < 2; ph++) begin
                logic [63:0] pat;
                int exp;
                pat = (ph == 0) ? ~64'h0 : ~(64'h1 << code);
                if (!assigned(code))   exp = 0;
                else if (code == 35)   exp = 6;
                else                   exp = (ph == 0) ? 5 : 0;
                wr(A_CTRL0, CLR);
                wr(A_CTRL0, EN | ST | 16'(code));
                idle(5, pat);
                wr(A_CTRL0, 16'h0000);
                rd_cnt(0, c);
                chk($sformatf("R4 R5 R6 code=%0h phase=%0d", code, ph), c, 64'(exp));
            end
        end
        rd_cnt(1, c); chk("R1 counter1 untouched by sweep", c, 0);

        // R1: two counters on different strobes at once; R2: clock-source flag has no effect
        wr(A_CTRL0, CLR); wr(A_CTRL1, CLR);
        wr(A_CTRL0, EN | ST | CKS | 16'h01);
        wr(A_CTRL1, EN | ST | 16'h02);
        idle(1, 64'h2); idle(1, 64'h4); idle(1, 64'h2); idle(1, 64'h6);
        idle(1, 64'h4); idle(1, 64'h4); idle(1, 64'h0);
        wr(A_CTRL0, 0); wr(A_CTRL1, 0);
        rd_cnt(0, c); chk("R1 R2 counter0 operand reads", c, 3);
        rd_cnt(1, c); chk("R1 counter1 operand writes", c, 4);

        // R7: stop holds, resume continues
        wr(A_CTRL0, CLR);
        wr(A_CTRL0, EN | ST | 16'h23);
        idle(9, '0);
        wr(A_CTRL0, 0);
        idle(5, ~64'h0);
        rd_cnt(0, c); chk("R7 hold after stop", c, 10);
        wr(A_CTRL0, EN | 16'h23);
        idle(3, '0);
        wr(A_CTRL0, 0);
        rd_cnt(0, c); chk("R4 enable without start does not count", c, 10);
        wr(A_CTRL0, EN | ST | 16'h23);
        idle(4, '0);
        wr(A_CTRL0, 0);
        rd_cnt(0, c); chk("R7 resume continues", c, 15);

        // R3: clear beats increment on the same edge
        wr(A_CTRL0, EN | ST | 16'h23);
        idle(3, '0);
        wr(A_CTRL0, EN | ST | CLR | 16'h23);
        idle(2, '0);
        wr(A_CTRL0, 0);
        rd_cnt(0, c); chk("R3 clear priority", c, 3);

        // R9: shadow coherency
        wr(A_CTRL0, CLR);
        wr(A_CTRL0, EN | ST | 16'h23);
        idle(69, '0);
        wr(A_CTRL0, 0);
        rd(A_HI0, v); chk("R8 high word", v, 1);
        wr(A_CTRL0, EN | ST | 16'h23);
        idle(3, '0);
        wr(A_CTRL0, 0);
        rd(A_LO0, v); chk("R9 low read returns shadow", v, 6);
        rd(A_LO0, v); chk("R9 second low read is live", v, 10);
        rd(A_HI1, v);
        rd(A_LO0, v); chk("R9 shadow is per counter", v, 10);
        rd(A_LO1, v); chk("R9 counter1 shadow", v, 4);

        // R10: wrap from maximum to zero
        wr(A_CTRL0, CLR);
        wr(A_CTRL0, EN | ST | 16'h23);
        idle(1022, '0);
        wr(A_CTRL0, 0);
        rd_cnt(0, c); chk("R10 reaches maximum", c, 64'd1023);
        wr(A_CTRL0, EN | ST | 16'h23);
        wr(A_CTRL0, 0);
        rd_cnt(0, c); chk("R10 wraps to zero", c, 0);
        wr(A_CTRL0, EN | ST | 16'h23);
        idle(2, '0);
        wr(A_CTRL0, 0);
        rd_cnt(0, c); chk("R10 counts on after wrap", c, 3);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule